// File: doc/BRIEF.md
# Parallel FIFO-Chip Byte Bridge

This block moves bytes between an on-chip byte stream and an external FIFO chip that is reached over a shared 8-bit parallel bus. The chip reports, on two active-low flags, whether it holds a byte for us and whether it has room for one. The block answers with two active-low strobes, one for reads and one for writes. The bus is split at the block's edge into an input half, an output half and an output-enable, which the pad ring combines into one tristate bus.

Every strobe is held low for a fixed number of clock cycles. After it rises, the block waits out the chip's flag recovery time plus the latency of the flag synchronisers before it looks at the flags again. Outbound bytes arrive on a sink port and inbound bytes leave on a source port, each with a strobe/acknowledge handshake. A full inbound holding register stops further reads. When both directions could run, they take turns.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While rst_ni is low, rd_no and wr_no are high, bus_oe_o, src_stb_o and snk_ack_o are low.
- R2: A read holds rd_no low for exactly STROBE_CYC cycles. The byte on bus_d_i during the last low cycle appears on src_data_o, with src_stb_o rising on the same edge on which rd_no rises. Bytes arrive in chip order.
- R3: Once src_stb_o is high, src_stb_o and src_data_o stay unchanged until a cycle with src_ack_i high. No read starts while src_stb_o is high.
- R4: snk_ack_o is high for one cycle per accepted byte. Throughout the following wr_no low period of STROBE_CYC cycles, bus_oe_o is high and bus_d_o carries that byte. Bytes leave in stream order.
- R5: rd_no and wr_no are never low together, and bus_oe_o is never high while rd_no is low.
- R6: After either strobe rises, both strobes stay high for at least RECOV_CYC + 2 cycles.
- R7: The status flags pass through two flip-flops. A read starts on the third rising edge after avail_ni falls, and no earlier.
- R8: When a read and a write are both possible, the block grants the direction it did not serve last.
- R9: STROBE_CYC = ceil((STROBE_NS + half a clock period) / clock period), and RECOV_CYC is computed the same way from RECOV_NS. The defaults (50 MHz, 50 ns, 49 ns) give 3 and 3.
- R10: No read starts while avail_ni is high. No write starts, and snk_ack_o stays low, while space_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| avail_ni | input | 1 | Chip holds a byte to read, active low |
| space_ni | input | 1 | Chip can take a byte, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| bus_d_i | input | 8 | Bus data from the chip |
| bus_d_o | output | 8 | Bus data to the chip |
| bus_oe_o | output | 1 | Drive enable for bus_d_o |
| snk_stb_i | input | 1 | Outbound byte valid |
| snk_data_i | input | 8 | Outbound byte |
| snk_ack_o | output | 1 | Outbound byte taken |
| src_stb_o | output | 1 | Inbound byte valid |
| src_data_o | output | 8 | Inbound byte |
| src_ack_i | input | 1 | Inbound byte taken |

## Verification
A read strobe falls on the third rising edge after the chip flag falls and stays low for STROBE_CYC cycles. The source strobe rises on the same edge as the read strobe, and the sink acknowledge is combinational in the cycle before the write strobe falls. The next strobe comes no sooner than RECOV_CYC + 2 high cycles later. The bench drives and samples on the falling clock edge, so each result is read half a cycle after the edge that produces it. The chip model counts low and high samples per strobe and compares them with counts it derives itself from the timing formula. Four rounds of 128 bytes each way sweep the stall rate of the stream ends from none to three in four.

// File: rtl/ufb_pkg.sv
`timescale 1ns/1ps
package ufb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RECOVER} ufb_state_e;

  // ceil((t + period/2) / period), in picoseconds
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_hz);
    longint unsigned per_ps, num;
    per_ps = 64'd1000000000000 / 64'(clk_hz);
    num    = 64'(t_ns) * 64'd1000 + per_ps / 64'd2;
    return 32'((num + per_ps - 64'd1) / per_ps);
  endfunction
endpackage

// File: rtl/ufb_sync.sv
`timescale 1ns/1ps
module ufb_sync #(
  parameter int          W   = 2,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ufb_timer.sv
`timescale 1ns/1ps
module ufb_timer #(
  parameter int TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= val_i;
    else if (!zero_o)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/usb_fifo_bridge.sv
`timescale 1ns/1ps
module usb_fifo_bridge
  import ufb_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned STROBE_NS = 50,
  parameter int unsigned RECOV_NS  = 49
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       avail_ni,
  input  logic       space_ni,
  output logic       rd_no,
  output logic       wr_no,
  input  logic [7:0] bus_d_i,
  output logic [7:0] bus_d_o,
  output logic       bus_oe_o,
  input  logic       snk_stb_i,
  input  logic [7:0] snk_data_i,
  output logic       snk_ack_o,
  output logic       src_stb_o,
  output logic [7:0] src_data_o,
  input  logic       src_ack_i
);
  localparam int SYNC_STAGES = 2;
  localparam int STROBE_CYC  = int'(ns_to_cyc(STROBE_NS, CLK_HZ));
  localparam int RECOV_CYC   = int'(ns_to_cyc(RECOV_NS, CLK_HZ));
  localparam int WAIT_CYC    = RECOV_CYC + SYNC_STAGES;
  localparam int MAX_CYC     = (STROBE_CYC > WAIT_CYC) ? STROBE_CYC : WAIT_CYC;
  localparam int TW          = $clog2(MAX_CYC + 1);

  ufb_state_e    state_q;
  logic          avail_s_n, space_s_n;
  logic          can_rd, can_wr, pick_rd, pick_wr;
  logic          prio_rd_q;
  logic          t_zero, t_load;
  logic [TW-1:0] t_val;

  ufb_sync #(.W(2), .RST(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({avail_ni, space_ni}),
    .q_o   ({avail_s_n, space_s_n})
  );

  // read needs an empty holding register; ties go to the direction not served last
  assign can_rd  = !avail_s_n && !src_stb_o;
  assign can_wr  = !space_s_n && snk_stb_i;
  assign pick_rd = can_rd && (prio_rd_q || !can_wr);
  assign pick_wr = can_wr && !pick_rd;

  assign snk_ack_o = (state_q == ST_IDLE) && pick_wr;

  always_comb begin
    t_load = 1'b0;
    t_val  = TW'(STROBE_CYC - 1);
    unique case (state_q)
      ST_IDLE:  t_load = pick_rd || pick_wr;
      ST_READ,
      ST_WRITE: begin
        t_load = t_zero;
        t_val  = TW'(WAIT_CYC - 1);
      end
      default:  t_load = 1'b0;
    endcase
  end

  ufb_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .val_i (t_val),
    .zero_o(t_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rd_no      <= 1'b1;
      wr_no      <= 1'b1;
      bus_oe_o   <= 1'b0;
      bus_d_o    <= '0;
      src_stb_o  <= 1'b0;
      src_data_o <= '0;
      prio_rd_q  <= 1'b1;
    end else begin
      if (src_stb_o && src_ack_i) src_stb_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (pick_rd) begin
            state_q   <= ST_READ;
            rd_no     <= 1'b0;
            prio_rd_q <= 1'b0;
          end else if (pick_wr) begin
            state_q   <= ST_WRITE;
            wr_no     <= 1'b0;
            bus_oe_o  <= 1'b1;
            bus_d_o   <= snk_data_i;
            prio_rd_q <= 1'b1;
          end
        end
        ST_READ: if (t_zero) begin
          rd_no      <= 1'b1;
          src_data_o <= bus_d_i;
          src_stb_o  <= 1'b1;
          state_q    <= ST_RECOVER;
        end
        ST_WRITE: if (t_zero) begin
          wr_no    <= 1'b1;
          bus_oe_o <= 1'b0;
          state_q  <= ST_RECOVER;
        end
        default: if (t_zero) state_q <= ST_IDLE;
      endcase
    end
  end

  // checker-only strobe length counter
  logic [TW-1:0] chk_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                chk_low_q <= '0;
    else if (!rd_no || !wr_no)  chk_low_q <= chk_low_q + 1'b1;
    else                        chk_low_q <= '0;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R5
  bus_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !bus_oe_o);
  // R3
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_stb_o && !src_ack_i) |=> (src_stb_o && $stable(src_data_o)));
  // R3
  rd_backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> !$past(src_stb_o));
  // R4
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_ack_o |=> (!snk_ack_o && !wr_no && bus_oe_o));
  // R4
  wr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && $past(!wr_no)) |-> ($stable(bus_d_o) && bus_oe_o));
  // R6
  recover_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_no) || $rose(wr_no)) |=> (rd_no && wr_no));
  // R9
  strobe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_no) || $rose(wr_no)) |-> (chk_low_q == TW'(STROBE_CYC)));
endmodule

// File: tb/usb_fifo_bridge_bench.sv
`timescale 1ns/1ps
module usb_fifo_bridge_bench;
  localparam int N = 128;
  localparam int ROUNDS = 4;
  localparam real PER_NS = 20.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       avail_n, space_n, rd_n, wr_n, oe;
  logic [7:0] din = 8'h00, dout;
  logic       snk_stb = 1'b0, snk_ack;
  logic [7:0] snk_data = 8'h00;
  logic       src_stb, src_ack = 1'b1;
  logic [7:0] src_data;

  always #10 clk = ~clk;

  usb_fifo_bridge u_usb_fifo_bridge (
    .clk_i(clk), .rst_ni(rst_n), .avail_ni(avail_n), .space_ni(space_n),
    .rd_no(rd_n), .wr_no(wr_n), .bus_d_i(din), .bus_d_o(dout), .bus_oe_o(oe),
    .snk_stb_i(snk_stb), .snk_data_i(snk_data), .snk_ack_o(snk_ack),
    .src_stb_o(src_stb), .src_data_o(src_data), .src_ack_i(src_ack)
  );

  int tests = 0, fails = 0;
  int strobe_exp, recov_exp;
  int rd_total = 0, snd_total = 0, stall = 0;
  bit tx_en = 1'b0, alt_on = 1'b0;

  // chip model state
  int  rd_idx = 0, wr_cnt = 0, rrec = 0, wrec = 0;
  int  low_run = 0, high_run = 1000, last_kind = -1;
  bit  prev_rd = 1'b1, prev_wr = 1'b1, prev_src = 1'b0;
  int  e_excl = 0, e_cont = 0, e_width = 0, e_gap = 0, e_bp = 0, e_flag = 0;
  int  e_wdata = 0, e_alt = 0, e_rdata = 0, e_hold = 0;
  int  snd_idx = 0, log_cnt = 0;

  function automatic logic [7:0] pkt(input int i);
    return 8'(i % N);
  endfunction

  assign avail_n = !(rd_idx < rd_total) || (rrec != 0);
  assign space_n = !tx_en || (wrec != 0);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe_start(input int kind);
    if (high_run < recov_exp + 2) e_gap++;
    if (alt_on && rd_idx < rd_total && wr_cnt < snd_total && kind == last_kind) e_alt++;
    last_kind = kind;
    high_run = 0;
    low_run = 1;
  endtask

  task automatic strobe_end();
    if (low_run != strobe_exp) e_width++;
    low_run = 0;
    high_run = 1;
  endtask

  // chip model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!rd_n && !wr_n) e_excl++;
        if (!rd_n && oe) e_cont++;
        if (prev_rd && !rd_n) begin
          if (avail_n) e_flag++;
          if (prev_src) e_bp++;
          din = pkt(rd_idx);
          strobe_start(0);
        end else if (prev_wr && !wr_n) begin
          if (space_n) e_flag++;
          if (!oe || dout != pkt(wr_cnt)) e_wdata++;
          strobe_start(1);
        end else if (!prev_rd && rd_n) begin
          strobe_end();
          rd_idx++;
          rrec = recov_exp + 1;
        end else if (!prev_wr && wr_n) begin
          strobe_end();
          wr_cnt++;
          wrec = recov_exp + 1;
        end else if (!rd_n || !wr_n) begin
          low_run++;
          if (!wr_n && (!oe || dout != pkt(wr_cnt))) e_wdata++;
        end else begin
          high_run++;
        end
        if (rrec != 0) rrec--;
        if (wrec != 0) wrec--;
        prev_rd = rd_n;
        prev_wr = wr_n;
        prev_src = src_stb;
      end
    end
  end

  // stream sink driver
  initial begin
    bit sent = 1'b0;
    forever begin
      @(negedge clk);
      if (sent) begin
        snd_idx++;
        snk_stb = 1'b0;
        sent = 1'b0;
      end
      if (!snk_stb && snd_idx < snd_total && int'($urandom % 4) >= stall) begin
        snk_stb = 1'b1;
        snk_data = pkt(snd_idx);
      end
      #1;
      if (snk_ack && !tx_en) e_flag++;
      sent = snk_stb && snk_ack;
    end
  end

  // stream source logger
  initial begin
    bit       hold = 1'b0;
    logic [7:0] hold_data = 8'h00;
    forever begin
      @(negedge clk);
      if (hold && (!src_stb || src_data != hold_data)) e_hold++;
      src_ack = (int'($urandom % 4) >= stall);
      if (src_stb && src_ack) begin
        if (src_data != pkt(log_cnt)) e_rdata++;
        log_cnt++;
      end
      hold = src_stb && !src_ack;
      hold_data = src_data;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bad;
    logic s1, s2, s3;
    strobe_exp = int'($ceil((50.0 + PER_NS / 2.0) / PER_NS));
    recov_exp  = int'($ceil((49.0 + PER_NS / 2.0) / PER_NS));
    repeat (3) @(negedge clk);
    chk("R1 rd_no", int'(rd_n), 1);
    chk("R1 wr_no", int'(wr_n), 1);
    chk("R1 bus_oe", int'(oe), 0);
    chk("R1 src_stb", int'(src_stb), 0);
    chk("R1 snk_ack", int'(snk_ack), 0);
    rst_n = 1'b1;

    // R10: bytes offered but no space, no data
    snd_total = N;
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (!wr_n || !rd_n || snk_ack) bad++;
    end
    chk("R10 no strobe while flags high", bad, 0);

    // R7: read starts on third edge after avail falls
    @(negedge clk);
    rd_total = N;
    @(negedge clk); s1 = rd_n;
    @(negedge clk); s2 = rd_n;
    @(negedge clk); s3 = rd_n;
    chk("R7 rd_no after edge 1", int'(s1), 1);
    chk("R7 rd_no after edge 2", int'(s2), 1);
    chk("R7 rd_no after edge 3", int'(s3), 0);
    tx_en = 1'b1;
    alt_on = 1'b1;

    for (int r = 0; r < ROUNDS; r++) begin
      if (r > 0) begin
        stall = r;
        rd_total += N;
        snd_total += N;
      end
      while (!(log_cnt == N * (r + 1) && wr_cnt == N * (r + 1))) @(negedge clk);
      if (r == 0) begin
        alt_on = 1'b0;
        chk("R8 alternation errors", e_alt, 0);
      end
      chk("R2 bytes received", log_cnt, N * (r + 1));
      chk("R2 read data errors", e_rdata, 0);
      chk("R4 bytes written", wr_cnt, N * (r + 1));
      chk("R4 write data errors", e_wdata, 0);
      chk("R3 hold/backpressure errors", e_hold + e_bp, 0);
      chk("R5 exclusion/contention errors", e_excl + e_cont, 0);
      chk("R6 recovery gap errors", e_gap, 0);
      chk("R9 strobe width errors", e_width, 0);
      chk("R10 flag violations", e_flag, 0);
    end
    repeat (10) @(negedge clk);
    chk("R9 expected strobe cycles", strobe_exp, 3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule